// File: doc/BRIEF.md
# Dual-Output Interrupt Controller Core

This block collects 64 level-sensitive interrupt sources and drives two request lines toward a processor. Each source is classed as normal or fast. Fast sources raise the fast line whenever one is pending and enabled. Normal sources raise the normal line subject to a 4-bit per-source priority and a 5-bit mask threshold. Software reaches the state through a simple register bus. The bus carries one 32-bit word per cycle and is word addressed. Read data is combinational in the cycle the read is presented.

Software can enable or disable a single source by writing its number. It can also rewrite whole 32-bit halves of the enable, type and pending vectors. Two acknowledge reads return the next source to service and clear its pending bit in the same cycle. The fast acknowledge picks the lowest-numbered fast source. The normal acknowledge uses a separate arbiter, which picks the highest priority and breaks ties toward the highest source number.

Top module: `irqc_core`

## Requirements
- R1: The 64-bit enable vector (word 4 = bits 63:32, word 5 = bits 31:0), the type vector (word 6 high, word 7 low; type 1 = fast) and the priority state all read back what was written. The priority state is held in words 8..15. Word 15 holds sources 0..7 and word 8 holds sources 56..63. Source i sits at bits 4*(i%8)+3 : 4*(i%8) of its word.
- R2: Words 18/19 read raw pending (high/low). Words 22/23 read pending & enabled & normal. Words 24/25 read pending & enabled & fast.
- R3: A write to word 2 sets the enable bit numbered by data bits 5:0. A write to word 3 clears that bit. Both words read as zero.
- R4: A write to word 20 replaces pending bits 63:32 and a write to word 21 replaces bits 31:0. Both words read as zero.
- R5: `irq_fast` is high exactly when some source is pending, enabled and typed fast.
- R6: `irq_norm` is low when no normal source is pending and enabled. When the mask is 0x1F it is high if any such source exists. For any other mask value it is high only if such a source has a priority strictly greater than the mask.
- R7: A read of word 17 returns the lowest-numbered pending, enabled, fast source and clears its pending bit. With none it returns 0xFFFFFFFF and changes nothing.
- R8: The mask (word 1) keeps only data bits 4:0. The control word (word 0) keeps only bits 24 and 22..18, so a write of all ones reads back 0x017C0000.
- R9: After reset, pending, enable, type, control and priorities are zero, the mask is 0x1F, and both outputs are low.
- R10: Writes to words 16..19 and 22..25 are ignored. Writes to words 0x40..0xBF are ignored as well. A read of word 0x40 returns 4.
- R11: A change of a source input sets the pending bit to the new level on the next clock edge. A steady input leaves the bit alone. When several updates hit the same edge, a force write wins over an acknowledge clear, which wins over a source change.
- R12: A read of word 16 returns (source << 16) | priority for the pending, enabled, normal source of highest priority, ties going to the higher number. It clears that source's pending bit. With none it returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 64 | Interrupt source levels, already synchronous |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
Read data is due in the same cycle as the read, so the bench samples it a short delay after presenting the access on a falling edge. Register writes, acknowledge clears and source changes all take effect on the following rising edge. The two request lines follow that edge with no further register. Every write and source change is therefore checked at the next falling edge. Acknowledge reads are followed by reads of the pending words, which shows the clear took effect one edge later.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // word offsets on the register bus
    localparam int OFS_CTRL       = 0;
    localparam int OFS_MASK       = 1;
    localparam int OFS_EN_NUM     = 2;
    localparam int OFS_DIS_NUM    = 3;
    localparam int OFS_EN_HI      = 4;
    localparam int OFS_EN_LO      = 5;
    localparam int OFS_TYPE_HI    = 6;
    localparam int OFS_TYPE_LO    = 7;
    localparam int OFS_PRIO_FIRST = 8;
    localparam int OFS_PRIO_LAST  = 15;
    localparam int OFS_NVEC       = 16;
    localparam int OFS_FVEC       = 17;
    localparam int OFS_RAW_HI     = 18;
    localparam int OFS_RAW_LO     = 19;
    localparam int OFS_FORCE_HI   = 20;
    localparam int OFS_FORCE_LO   = 21;
    localparam int OFS_NPEND_HI   = 22;
    localparam int OFS_NPEND_LO   = 23;
    localparam int OFS_FPEND_HI   = 24;
    localparam int OFS_FPEND_LO   = 25;
    localparam int OFS_CONST      = 64;

    localparam logic [31:0] CTRL_KEEP   = 32'h017C_0000;
    localparam logic [31:0] NONE_WORD   = 32'hFFFF_FFFF;
    localparam logic [31:0] CONST_WORD  = 32'h0000_0004;
endpackage

// File: rtl/irqc_norm_arb.sv
module irqc_norm_arb #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int MASK_W  = 5,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        flags,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [MASK_W-1:0]         mask,
    output logic                      hit_vld,
    output logic [IDX_W-1:0]          hit_idx,
    output logic [PRIO_W-1:0]         hit_prio,
    output logic                      above_mask
);
    // linear scan upward; ">=" lets a later (higher) source win a tie
    always_comb begin
        hit_vld    = 1'b0;
        hit_idx    = '0;
        hit_prio   = '0;
        above_mask = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (flags[i]) begin
                if (!hit_vld || prio_flat[i*PRIO_W +: PRIO_W] >= hit_prio) begin
                    hit_vld  = 1'b1;
                    hit_idx  = IDX_W'(i);
                    hit_prio = prio_flat[i*PRIO_W +: PRIO_W];
                end
                if (MASK_W'(prio_flat[i*PRIO_W +: PRIO_W]) > mask)
                    above_mask = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqc_fast_pick.sv
module irqc_fast_pick #(
    parameter int NUM_SRC = 64,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] flags,
    output logic               pick_vld,
    output logic [IDX_W-1:0]   pick_idx
);
    // downward scan: the last hit is the lowest number
    always_comb begin
        pick_vld = 1'b0;
        pick_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (flags[i]) begin
                pick_vld = 1'b1;
                pick_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_core.sv
module irqc_core
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 10,
    parameter int PRIO_W  = 4,
    parameter int MASK_W  = 5,
    localparam int IDX_W   = $clog2(NUM_SRC),
    localparam int PW_NUM  = NUM_SRC * PRIO_W / DATA_W,
    localparam int PW_IDX_W = $clog2(PW_NUM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_norm,
    output logic               irq_fast
);
    logic [NUM_SRC-1:0]        pend_q, pend_nx, en_q, type_q, src_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_q;
    logic [MASK_W-1:0]         mask_q;
    logic [DATA_W-1:0]         ctrl_q;

    logic [NUM_SRC-1:0] norm_flags, fast_flags;
    logic               norm_vld, norm_above, fast_vld;
    logic [IDX_W-1:0]   norm_idx, fast_idx;
    logic [PRIO_W-1:0]  norm_prio;

    logic wr_en, rd_en, ack_norm, ack_fast, prio_hit;
    logic [PW_IDX_W-1:0] pw_idx;

    assign norm_flags = pend_q & en_q & ~type_q;
    assign fast_flags = pend_q & en_q & type_q;

    irqc_norm_arb #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)
    ) u_arb (
        .flags(norm_flags), .prio_flat(prio_q), .mask(mask_q),
        .hit_vld(norm_vld), .hit_idx(norm_idx), .hit_prio(norm_prio),
        .above_mask(norm_above)
    );

    irqc_fast_pick #(.NUM_SRC(NUM_SRC)) u_fast (
        .flags(fast_flags), .pick_vld(fast_vld), .pick_idx(fast_idx)
    );

    assign wr_en    = bus_sel && bus_wr;
    assign rd_en    = bus_sel && !bus_wr;
    assign ack_norm = rd_en && (bus_addr == ADDR_W'(OFS_NVEC)) && norm_vld;
    assign ack_fast = rd_en && (bus_addr == ADDR_W'(OFS_FVEC)) && fast_vld;
    assign prio_hit = (bus_addr >= ADDR_W'(OFS_PRIO_FIRST)) &&
                      (bus_addr <= ADDR_W'(OFS_PRIO_LAST));
    assign pw_idx   = PW_IDX_W'(ADDR_W'(OFS_PRIO_LAST) - bus_addr);

    // request outputs
    assign irq_fast = |fast_flags;
    assign irq_norm = (|norm_flags) && ((&mask_q) || norm_above);

    // pending next state: source change < acknowledge < force
    always_comb begin
        pend_nx = pend_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_lvl[i] != src_q[i])
                pend_nx[i] = src_lvl[i];
        end
        if (ack_fast) pend_nx[fast_idx] = 1'b0;
        if (ack_norm) pend_nx[norm_idx] = 1'b0;
        if (wr_en && bus_addr == ADDR_W'(OFS_FORCE_HI))
            pend_nx[NUM_SRC-1:DATA_W] = bus_wdata;
        if (wr_en && bus_addr == ADDR_W'(OFS_FORCE_LO))
            pend_nx[DATA_W-1:0] = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            src_q  <= '0;
        end else begin
            pend_q <= pend_nx;
            src_q  <= src_lvl;
        end
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            type_q <= '0;
            prio_q <= '0;
            mask_q <= '1;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (prio_hit) begin
                prio_q[pw_idx*DATA_W +: DATA_W] <= bus_wdata;
            end else begin
                unique case (bus_addr)
                    ADDR_W'(OFS_CTRL):    ctrl_q <= bus_wdata & CTRL_KEEP;
                    ADDR_W'(OFS_MASK):    mask_q <= bus_wdata[MASK_W-1:0];
                    ADDR_W'(OFS_EN_NUM):  en_q[bus_wdata[IDX_W-1:0]] <= 1'b1;
                    ADDR_W'(OFS_DIS_NUM): en_q[bus_wdata[IDX_W-1:0]] <= 1'b0;
                    ADDR_W'(OFS_EN_HI):   en_q[NUM_SRC-1:DATA_W]   <= bus_wdata;
                    ADDR_W'(OFS_EN_LO):   en_q[DATA_W-1:0]         <= bus_wdata;
                    ADDR_W'(OFS_TYPE_HI): type_q[NUM_SRC-1:DATA_W] <= bus_wdata;
                    ADDR_W'(OFS_TYPE_LO): type_q[DATA_W-1:0]       <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (prio_hit) begin
            bus_rdata = prio_q[pw_idx*DATA_W +: DATA_W];
        end else begin
            unique case (bus_addr)
                ADDR_W'(OFS_CTRL):     bus_rdata = ctrl_q;
                ADDR_W'(OFS_MASK):     bus_rdata = DATA_W'(mask_q);
                ADDR_W'(OFS_EN_HI):    bus_rdata = en_q[NUM_SRC-1:DATA_W];
                ADDR_W'(OFS_EN_LO):    bus_rdata = en_q[DATA_W-1:0];
                ADDR_W'(OFS_TYPE_HI):  bus_rdata = type_q[NUM_SRC-1:DATA_W];
                ADDR_W'(OFS_TYPE_LO):  bus_rdata = type_q[DATA_W-1:0];
                ADDR_W'(OFS_NVEC):     bus_rdata = norm_vld ?
                    ((DATA_W'(norm_idx) << 16) | DATA_W'(norm_prio)) : NONE_WORD;
                ADDR_W'(OFS_FVEC):     bus_rdata = fast_vld ? DATA_W'(fast_idx) : NONE_WORD;
                ADDR_W'(OFS_RAW_HI):   bus_rdata = pend_q[NUM_SRC-1:DATA_W];
                ADDR_W'(OFS_RAW_LO):   bus_rdata = pend_q[DATA_W-1:0];
                ADDR_W'(OFS_NPEND_HI): bus_rdata = norm_flags[NUM_SRC-1:DATA_W];
                ADDR_W'(OFS_NPEND_LO): bus_rdata = norm_flags[DATA_W-1:0];
                ADDR_W'(OFS_FPEND_HI): bus_rdata = fast_flags[NUM_SRC-1:DATA_W];
                ADDR_W'(OFS_FPEND_LO): bus_rdata = fast_flags[DATA_W-1:0];
                ADDR_W'(OFS_CONST):    bus_rdata = CONST_WORD;
                default:               bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_core_chk.sv
module irqc_core_chk #(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 10,
    parameter int MASK_W  = 5,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_norm,
    input logic               irq_fast,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] type_q,
    input logic [MASK_W-1:0]  mask_q
);
    AST_EN_BY_NUM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(2)) |=> en_q[$past(bus_wdata[IDX_W-1:0])]); // R3
    AST_DIS_BY_NUM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(3)) |=> !en_q[$past(bus_wdata[IDX_W-1:0])]); // R3
    AST_FORCE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == ADDR_W'(20) || bus_addr == ADDR_W'(21))) |-> bus_rdata == '0); // R4
    AST_FAST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_fast); // R5
    AST_NORM_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((&mask_q) && |(pend_q & en_q & ~type_q)) |-> irq_norm); // R6
    AST_FAST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(17) && bus_rdata != '1)
        |=> !pend_q[$past(bus_rdata[IDX_W-1:0])]); // R7
    AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(1)) |=> mask_q == $past(bus_wdata[MASK_W-1:0])); // R8
endmodule

bind irqc_core irqc_core_chk #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_norm(irq_norm), .irq_fast(irq_fast), .en_q(en_q), .pend_q(pend_q),
    .type_q(type_q), .mask_q(mask_q)
);

// File: tb/sim_irqc_core.sv
module sim_irqc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_lvl = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_fast;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irqc_core u0 (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 40;
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 10'd0,  32'hFFFF_FFFF, 32'h0, 8'd8},
        '{1'b0, 10'd0,  32'h0, 32'h017C_0000, 8'd8},   // R8 control keep bits
        '{1'b1, 10'd1,  32'hFFFF_FFE3, 32'h0, 8'd8},
        '{1'b0, 10'd1,  32'h0, 32'h0000_0003, 8'd8},   // R8 mask width
        '{1'b1, 10'd1,  32'h0000_001F, 32'h0, 8'd8},
        '{1'b1, 10'd4,  32'h1234_5678, 32'h0, 8'd1},
        '{1'b0, 10'd4,  32'h0, 32'h1234_5678, 8'd1},   // R1
        '{1'b1, 10'd5,  32'h0000_00F0, 32'h0, 8'd1},
        '{1'b1, 10'd2,  32'h0000_0041, 32'h0, 8'd3},
        '{1'b0, 10'd5,  32'h0, 32'h0000_00F2, 8'd3},   // R3 enable by number
        '{1'b1, 10'd3,  32'h0000_0004, 32'h0, 8'd3},
        '{1'b0, 10'd5,  32'h0, 32'h0000_00E2, 8'd3},   // R3 disable by number
        '{1'b0, 10'd2,  32'h0, 32'h0, 8'd3},
        '{1'b0, 10'd3,  32'h0, 32'h0, 8'd3},
        '{1'b1, 10'd6,  32'hAAAA_0000, 32'h0, 8'd1},
        '{1'b0, 10'd6,  32'h0, 32'hAAAA_0000, 8'd1},   // R1
        '{1'b1, 10'd7,  32'h0000_0005, 32'h0, 8'd1},
        '{1'b0, 10'd7,  32'h0, 32'h0000_0005, 8'd1},
        '{1'b1, 10'd8,  32'h8765_4321, 32'h0, 8'd1},
        '{1'b0, 10'd8,  32'h0, 32'h8765_4321, 8'd1},   // R1 priority word
        '{1'b1, 10'd20, 32'h0000_0003, 32'h0, 8'd4},
        '{1'b0, 10'd18, 32'h0, 32'h0000_0003, 8'd4},   // R4 force high
        '{1'b0, 10'd20, 32'h0, 32'h0, 8'd4},
        '{1'b1, 10'd18, 32'h0000_0001, 32'h0, 8'd10},
        '{1'b0, 10'd18, 32'h0, 32'h0000_0003, 8'd10},  // R10 read-only write
        '{1'b0, 10'd64, 32'h0, 32'h0000_0004, 8'd10},  // R10 constant word
        '{1'b1, 10'd66, 32'h0000_0000, 32'h0, 8'd10},
        '{1'b0, 10'd5,  32'h0, 32'h0000_00E2, 8'd10},  // R10 ignored range
        '{1'b1, 10'd21, 32'h0000_0012, 32'h0, 8'd4},
        '{1'b0, 10'd19, 32'h0, 32'h0000_0012, 8'd4},
        '{1'b0, 10'd21, 32'h0, 32'h0, 8'd4},
        '{1'b0, 10'd23, 32'h0, 32'h0000_0002, 8'd2},   // R2 normal view
        '{1'b0, 10'd25, 32'h0, 32'h0000_0000, 8'd2},
        '{1'b1, 10'd7,  32'h0000_0007, 32'h0, 8'd2},
        '{1'b0, 10'd25, 32'h0, 32'h0000_0002, 8'd2},   // R2 fast view
        '{1'b0, 10'd23, 32'h0, 32'h0000_0000, 8'd2},
        '{1'b0, 10'd17, 32'h0, 32'h0000_0001, 8'd7},   // R7 fast ack
        '{1'b0, 10'd25, 32'h0, 32'h0000_0000, 8'd7},
        '{1'b0, 10'd19, 32'h0, 32'h0000_0010, 8'd7},
        '{1'b0, 10'd17, 32'h0, 32'hFFFF_FFFF, 8'd7}    // R7 none left
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src_lvl = v;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_lvl = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            if (TBL[k].wr) wr(TBL[k].addr, TBL[k].data);
            else begin
                rd(TBL[k].addr, d);
                check(int'(TBL[k].req), d, TBL[k].exp);
            end
        end

        // R9 reset state
        do_reset();
        @(negedge clk);
        check(9, {30'd0, irq_norm, irq_fast}, 32'h0);
        rd(10'd1, d); check(9, d, 32'h1F);
        rd(10'd0, d); check(9, d, 32'h0);
        rd(10'd5, d); check(9, d, 32'h0);
        rd(10'd7, d); check(9, d, 32'h0);
        rd(10'd15, d); check(9, d, 32'h0);
        rd(10'd19, d); check(9, d, 32'h0);

        // R6 normal output gating
        wr(10'd5, 32'hFF);
        wr(10'd15, 32'h0000_5030);
        set_src(64'h1);
        check(6, {31'd0, irq_norm}, 32'd1);       // R11 source rise seen
        check(5, {31'd0, irq_fast}, 32'd0);
        wr(10'd1, 32'd0);
        check(6, {31'd0, irq_norm}, 32'd0);       // prio 0 not above 0
        set_src(64'h3);
        check(6, {31'd0, irq_norm}, 32'd1);       // prio 3 above 0
        wr(10'd1, 32'd3);
        check(6, {31'd0, irq_norm}, 32'd0);       // strict compare
        wr(10'd1, 32'd2);
        check(6, {31'd0, irq_norm}, 32'd1);
        wr(10'd1, 32'd16);
        check(6, {31'd0, irq_norm}, 32'd0);
        wr(10'd1, 32'h1F);
        check(6, {31'd0, irq_norm}, 32'd1);

        // R12 normal vector reads
        wr(10'd15, 32'h0000_5530);
        set_src(64'hF);
        rd(10'd16, d); check(12, d, 32'h0003_0005);
        rd(10'd16, d); check(12, d, 32'h0002_0005);
        rd(10'd16, d); check(12, d, 32'h0001_0003);
        rd(10'd16, d); check(12, d, 32'h0000_0000);
        rd(10'd16, d); check(12, d, 32'hFFFF_FFFF);
        rd(10'd19, d); check(12, d, 32'h0);
        @(negedge clk);
        check(12, {31'd0, irq_norm}, 32'd0);

        // R5 fast output
        wr(10'd7, 32'h100);
        wr(10'd2, 32'd8);
        set_src(64'h10F);
        check(5, {31'd0, irq_fast}, 32'd1);
        check(5, {31'd0, irq_norm}, 32'd0);
        wr(10'd3, 32'd8);
        check(3, {31'd0, irq_fast}, 32'd0);

        // R11 force wins over a simultaneous source change
        @(negedge clk);
        src_lvl = 64'h30F;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'd21; bus_wdata = 32'h0;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(10'd19, d); check(11, d, 32'h0);

        // R11 rise and fall tracking
        set_src(64'h70F);
        rd(10'd19, d); check(11, d, 32'h0000_0400);
        set_src(64'h30F);
        rd(10'd19, d); check(11, d, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule